// File: doc/BRIEF.md
# Key-Locked Memory Controller Register Bank

This block is the software-visible configuration bank of a DRAM controller, sitting on a plain 32-bit word bus with a byte address, a write strobe, a read strobe and registered read data. Word 0 holds a protection key. Until the key word contains the unlock value, writes to every other word are refused and flagged with a one-cycle error pulse. The key word itself is always writable, so software unlocks the bank, programs it and may lock it again.

Word 1 is the controller configuration word. Some of its fields are fixed by hardware and cannot be changed by software. A build-time variant parameter selects which fields are fixed, how the two-bit memory size code is read, and the reset value. The size code comes from a memory-size parameter given in megabytes. Accesses whose word index lies past the implemented register count, but inside the 4 KiB window, read as zero, change nothing and raise their own one-cycle error pulse.

Top module: `mcreg_bank`

## Requirements
- R1: With VARIANT=0, reset loads the configuration word (word 1) with bit 6 set and the size code in bits 1:0, where 64/128/256/512 MB give codes 0/1/2/3. Every other word resets to zero.
- R2: With VARIANT=1, reset loads the configuration word with 1 in bits 31:28, 3 in bits 3:2 and the size code in bits 1:0, where 128/256/512/1024 MB give codes 0/1/2/3.
- R3: A DRAM_MB value that is not legal for the selected variant gives size code 0.
- R4: A write to word 0 (byte address 0x000) is always accepted and raises no error.
- R5: A write to any word 1..NUM_REGS-1 while word 0 differs from 0xFC600309 leaves the word unchanged and raises locked_err for exactly one cycle, the cycle after the write. The same write is accepted once word 0 equals that key.
- R6: With VARIANT=0, an accepted write to the configuration word keeps bits 31:11, bit 6 and bits 3:2 and takes every other bit from the write data.
- R7: With VARIANT=1, an accepted write to the configuration word keeps bits 31:28, 19, 18:14, 6 and 3:2 and takes every other bit from the write data.
- R8: The word index is address bits 11:2. An access with an index of NUM_REGS or more reads as zero, writes nothing and raises range_err for one cycle, the cycle after the access. It never raises locked_err.
- R9: rd_data shows the addressed word one cycle after rd_en and holds its value while rd_en is low. A read and a write of the same word in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| locked_err | output | 1 | One-cycle pulse for a write refused by the key |
| range_err | output | 1 | One-cycle pulse for an access past the register count |

## Verification
A read and a write can address the same word in the same cycle. The bench issues both strobes together to a word that holds a known value with a new value on the write data. It expects the old value on rd_data in the following cycle and the new value from a separate read after that. It also aims a locked write at an index that is past the register count but aliases word 0 in its low bits. Only range_err may pulse there, and the key word must read back unchanged.

// File: rtl/mcreg_pkg.sv
// Package: constants and build-time helpers shared by the register bank.
// Assumes a 32-bit data word and a two-variant configuration layout.
package mcreg_pkg;

    localparam int          DATA_W     = 32;
    localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

    // Fixed-field pieces of the configuration word, variant 0
    localparam logic [31:0] A_RSVD  = 32'hFFFF_F800;
    // Fixed-field pieces shared by both variants
    localparam logic [31:0] DISP_COMPAT = 32'h0000_0040;
    localparam logic [31:0] DISP_APERT  = 32'h0000_000C;
    // Fixed-field pieces, variant 1
    localparam logic [31:0] B_HWVER    = 32'hF000_0000;
    localparam logic [31:0] B_INITDONE = 32'h0008_0000;
    localparam logic [31:0] B_RSVD     = 32'h0007_C000;

    // Size code for the selected variant; illegal sizes fall back to 0
    function automatic logic [1:0] size_code(input int variant, input int mb);
        logic [1:0] code;
        code = 2'd0;
        if (variant == 0) begin
            case (mb)
                128:     code = 2'd1;
                256:     code = 2'd2;
                512:     code = 2'd3;
                default: code = 2'd0;
            endcase
        end else begin
            case (mb)
                256:     code = 2'd1;
                512:     code = 2'd2;
                1024:    code = 2'd3;
                default: code = 2'd0;
            endcase
        end
        return code;
    endfunction

    // Bits of the configuration word that software cannot change
    function automatic logic [31:0] ro_mask(input int variant);
        if (variant == 0)
            return A_RSVD | DISP_COMPAT | DISP_APERT;
        return B_HWVER | B_INITDONE | B_RSVD | DISP_COMPAT | DISP_APERT;
    endfunction

    // Reset value of the configuration word
    function automatic logic [31:0] cfg_reset(input int variant, input int mb);
        logic [31:0] v;
        if (variant == 0)
            v = DISP_COMPAT;
        else
            v = 32'h1000_0000 | DISP_APERT;
        v[1:0] = size_code(variant, mb);
        return v;
    endfunction

endpackage

// File: rtl/mcreg_decode.sv
// Address decode: turns a byte address into a word index and flags.
// Assumes word-wide accesses only, so the two low address bits are dropped.
module mcreg_decode #(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              hit_key
);
    localparam logic [IDX_W:0] NR_W = (IDX_W + 1)'(NUM_REGS);

    logic unused_lo;

    // Byte lanes are not decoded: every access is a full word
    assign unused_lo = ^addr[1:0];

    // Word index, range test and key-word hit
    always_comb begin
        idx      = addr[ADDR_W-1:2];
        in_range = ({1'b0, idx} < NR_W);
        hit_key  = (idx == '0);
    end

endmodule

// File: rtl/mcreg_gate.sv
// Write gate: decides whether a write may land and raises error pulses.
// Assumes the key word value comes straight from storage (current state).
// Range failure takes precedence: an out-of-range access never flags lock.
module mcreg_gate (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        in_range,
    input  logic        hit_key,
    input  logic [31:0] key_val,
    output logic        wr_accept,
    output logic        locked_err,
    output logic        range_err
);
    import mcreg_pkg::*;

    logic unlocked;
    logic lock_drop;
    logic range_hit;

    // Combinational accept and error conditions for this cycle
    always_comb begin
        unlocked  = (key_val == UNLOCK_KEY);
        wr_accept = wr_en && in_range && (hit_key || unlocked);
        lock_drop = wr_en && in_range && !hit_key && !unlocked;
        range_hit = (wr_en || rd_en) && !in_range;
    end

    // Register the error pulses so they line up with read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_err <= 1'b0;
            range_err  <= 1'b0;
        end else begin
            locked_err <= lock_drop;
            range_err  <= range_hit;
        end
    end

endmodule

// File: rtl/mcreg_store.sv
// Register storage: one flop word per register, built by generate.
// The configuration word merges write data through a fixed read-only mask;
// all other words take the full write data.
module mcreg_store #(
    parameter int          NUM_REGS = 16,
    parameter int          IDX_W    = 10,
    parameter int          CFG_IDX  = 1,
    parameter logic [31:0] RO_MASK  = 32'h0,
    parameter logic [31:0] CFG_RST  = 32'h0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_accept,
    input  logic [IDX_W-1:0]          idx,
    input  logic [31:0]               wr_data,
    output logic [NUM_REGS-1:0][31:0] regs
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        logic hit;

        // Per-word write select
        assign hit = wr_accept && (idx == IDX_W'(r));

        if (r == CFG_IDX) begin : g_cfg
            // Configuration word: fixed fields keep their value
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[r] <= CFG_RST;
                else if (hit)
                    regs[r] <= (regs[r] & RO_MASK) | (wr_data & ~RO_MASK);
            end
        end else begin : g_plain
            // Plain word: fully writable, resets to zero
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[r] <= '0;
                else if (hit)
                    regs[r] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mcreg_rdport.sv
// Read port: selects the addressed word and registers it.
// Assumes storage is read before this cycle's write lands (old data).
module mcreg_rdport #(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic                      in_range,
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_REGS-1:0][31:0] regs,
    output logic [31:0]               rd_data
);
    logic [31:0] sel;

    // Word select as a flat mux over the implemented registers
    always_comb begin
        sel = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (idx == IDX_W'(r))
                sel = regs[r];
    end

    // Capture on read strobe; out-of-range reads return zero; hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= in_range ? sel : '0;
    end

endmodule

// File: rtl/mcreg_bank.sv
// Top: key-locked configuration register bank of a DRAM controller.
// VARIANT selects the configuration layout (0 or 1); DRAM_MB sets the
// reset size code. NUM_REGS words are implemented inside a 2**ADDR_W byte
// window; word 0 is the key, word 1 is the configuration word.
module mcreg_bank #(
    parameter int VARIANT  = 0,
    parameter int DRAM_MB  = 256,
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              locked_err,
    output logic              range_err
);
    import mcreg_pkg::*;

    localparam int          IDX_W   = ADDR_W - 2;
    localparam int          CFG_IDX = 1;
    localparam logic [31:0] RO_M    = ro_mask(VARIANT);
    localparam logic [31:0] RST_V   = cfg_reset(VARIANT, DRAM_MB);

    logic [IDX_W-1:0]          idx;
    logic                      in_range;
    logic                      hit_key;
    logic                      wr_accept;
    logic [NUM_REGS-1:0][31:0] regs;

    mcreg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .addr     (addr),
        .idx      (idx),
        .in_range (in_range),
        .hit_key  (hit_key)
    );

    mcreg_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .in_range   (in_range),
        .hit_key    (hit_key),
        .key_val    (regs[0]),
        .wr_accept  (wr_accept),
        .locked_err (locked_err),
        .range_err  (range_err)
    );

    mcreg_store #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .CFG_IDX  (CFG_IDX),
        .RO_MASK  (RO_M),
        .CFG_RST  (RST_V)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .idx       (idx),
        .wr_data   (wr_data),
        .regs      (regs)
    );

    mcreg_rdport #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .in_range (in_range),
        .idx      (idx),
        .regs     (regs),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mcreg_bank_chk.sv
// Checker: temporal properties of the register bank, bound to the top.
// Observes the bus ports plus the key and configuration words.
module mcreg_bank_chk #(
    parameter int VARIANT  = 0,
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              locked_err,
    input logic              range_err,
    input logic [31:0]       key_val,
    input logic [31:0]       cfg_val
);
    import mcreg_pkg::*;

    localparam int             IDX_W = ADDR_W - 2;
    localparam logic [IDX_W:0] NR_W  = (IDX_W + 1)'(NUM_REGS);
    localparam logic [31:0]    RO_M  = ro_mask(VARIANT);

    logic far;
    logic locked_wr;

    // Access classification seen from the bus
    always_comb begin
        far       = ({1'b0, addr[ADDR_W-1:2]} >= NR_W);
        locked_wr = wr_en && !far && (addr[ADDR_W-1:2] != '0)
                    && (key_val != UNLOCK_KEY);
    end

    // R5
    locked_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_wr |=> locked_err);

    // R5
    locked_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_wr && addr[ADDR_W-1:2] == IDX_W'(1)) |=> $stable(cfg_val));

    // R8
    range_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && far) |=> (range_err && !locked_err));

    // R8
    range_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && far) |=> (rd_data == 32'h0));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R6
    // R7
    cfg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cfg_val & RO_M));

endmodule

bind mcreg_bank mcreg_bank_chk #(
    .VARIANT  (VARIANT),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .locked_err (locked_err),
    .range_err  (range_err),
    .key_val    (regs[0]),
    .cfg_val    (regs[1])
);

// File: tb/mcreg_bank_test.sv
`timescale 1ns/1ps
// Directed bench: three variants share one bus and are checked side by side.
module mcreg_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;

    logic [31:0] rd_a, rd_b, rd_x;
    logic        le_a, le_b, le_x, re_a, re_b, re_x;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // Variant 0, 256 MB
    mcreg_bank #(.VARIANT(0), .DRAM_MB(256)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_a),
        .locked_err(le_a), .range_err(re_a));

    // Variant 1, 1024 MB
    mcreg_bank #(.VARIANT(1), .DRAM_MB(1024)) uut_b (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_b),
        .locked_err(le_b), .range_err(re_b));

    // Variant 1, illegal size
    mcreg_bank #(.VARIANT(1), .DRAM_MB(300)) uut_x (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_x),
        .locked_err(le_x), .range_err(re_x));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One bus cycle; outputs are sampled 1 ns after the capturing edge
    task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d, input logic re);
        @(negedge clk);
        addr = a; wr_en = we; wr_data = d; rd_en = re;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic t_reset();
        step(12'h004, 1'b0, '0, 1'b1);
        chk("R1 cfg v0", rd_a, 32'h0000_0042);
        chk("R2 cfg v1", rd_b, 32'h1000_000F);
        chk("R3 cfg illegal size", rd_x, 32'h1000_000C);
        step(12'h014, 1'b0, '0, 1'b1);
        chk("R1 word5 zero", rd_a, 32'h0);
        chk("R1 err idle", {30'b0, le_a, re_a}, 32'h0);
    endtask

    task automatic t_locked();
        step(12'h008, 1'b1, 32'h0000_1234, 1'b0);
        chk("R5 locked_err", {31'b0, le_a}, 32'h1);
        chk("R5 no range_err", {31'b0, re_a}, 32'h0);
        step(12'h000, 1'b0, '0, 1'b0);
        chk("R5 pulse one cycle", {31'b0, le_a}, 32'h0);
        step(12'h008, 1'b0, '0, 1'b1);
        chk("R5 word2 unchanged", rd_a, 32'h0);
        step(12'h004, 1'b1, 32'hFFFF_FFFF, 1'b0);
        step(12'h004, 1'b0, '0, 1'b1);
        chk("R5 cfg unchanged", rd_a, 32'h0000_0042);
    endtask

    task automatic t_unlock();
        step(12'h000, 1'b1, 32'hFC60_0309, 1'b0);
        chk("R4 key write no err", {30'b0, le_a, re_a}, 32'h0);
        step(12'h000, 1'b0, '0, 1'b1);
        chk("R4 key readback", rd_a, 32'hFC60_0309);
        step(12'h008, 1'b1, 32'h0000_A5A5, 1'b0);
        chk("R5 unlocked accept no err", {31'b0, le_a}, 32'h0);
        step(12'h008, 1'b0, '0, 1'b1);
        chk("R5 word2 written", rd_a, 32'h0000_A5A5);
    endtask

    task automatic t_cfg_mask();
        step(12'h004, 1'b1, 32'hFFFF_FFFF, 1'b0);
        step(12'h004, 1'b0, '0, 1'b1);
        chk("R6 cfg v0 ones", rd_a, 32'h0000_07F3);
        chk("R7 cfg v1 ones", rd_b, 32'h1FF0_3FBF);
        chk("R7 cfg illegal ones", rd_x, 32'h1FF0_3FBF);
        step(12'h004, 1'b1, 32'h0, 1'b0);
        step(12'h004, 1'b0, '0, 1'b1);
        chk("R6 cfg v0 zeros", rd_a, 32'h0000_0040);
        chk("R7 cfg v1 zeros", rd_b, 32'h1000_000C);
    endtask

    task automatic t_range();
        step(12'h040, 1'b1, 32'h0000_DEAD, 1'b0);
        chk("R8 range_err write", {30'b0, le_a, re_a}, 32'h1);
        step(12'h000, 1'b0, '0, 1'b1);
        chk("R8 key not aliased", rd_a, 32'hFC60_0309);
        chk("R8 pulse one cycle", {31'b0, re_a}, 32'h0);
        step(12'hFFC, 1'b0, '0, 1'b1);
        chk("R8 far read zero", rd_a, 32'h0);
        chk("R8 range_err read", {31'b0, re_a}, 32'h1);
    endtask

    task automatic t_latency();
        step(12'h008, 1'b0, '0, 1'b1);
        chk("R9 read word2", rd_a, 32'h0000_A5A5);
        step(12'h004, 1'b0, '0, 1'b0);
        chk("R9 hold", rd_a, 32'h0000_A5A5);
        step(12'h008, 1'b1, 32'h0000_5A5A, 1'b1);
        chk("R9 same-cycle old value", rd_a, 32'h0000_A5A5);
        step(12'h008, 1'b0, '0, 1'b1);
        chk("R9 new value", rd_a, 32'h0000_5A5A);
    endtask

    task automatic t_relock();
        step(12'h000, 1'b1, 32'h0, 1'b0);
        step(12'h008, 1'b1, 32'h0000_0001, 1'b0);
        chk("R5 relocked err", {31'b0, le_a}, 32'h1);
        step(12'h008, 1'b0, '0, 1'b1);
        chk("R5 relocked unchanged", rd_a, 32'h0000_5A5A);
    endtask

    // Main sequence
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_unlock();
        t_cfg_mask();
        t_range();
        t_latency();
        t_relock();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule